// File: doc/BRIEF.md
# Cartridge Bank Controller with Real-Time Clock

This block sits between a handheld CPU's 16-bit address bus and the memory chips of a game cartridge. The CPU never writes into ROM. Instead, writes that land in the lower half of the address space are decoded as control commands. From those commands the block keeps a switchable ROM bank number, an enable for the external window, and a select code. It then produces the upper physical address bits for the ROM and RAM arrays. The CPU region 0000-3FFF always maps to the first physical ROM bank. The region 4000-7FFF maps to whichever bank the software chose. A bank number of zero is moved to bank one, so that the two regions never show the same data.

The window at A000-BFFF is shared. It reaches one of four external RAM banks, or one of five clock registers, depending on the select code. The block counts seconds, minutes, hours and a 9-bit day number, driven by a once-per-second enable. The clock can be halted, and it raises a sticky carry when the day count wraps. The CPU never reads the running counters directly. A two-write command copies them into a frozen set, and the CPU reads that frozen set at its leisure. Software can also write the running counters through the same window.

Top module: `cart_bank_ctrl`

## Requirements
- R1: For any CPU address below 8000 with bit 14 clear, romAddr equals {zeros, cpuAddr[13:0]}, i.e. physical bank 0.
- R2: A write anywhere in 2000-3FFF stores cpuWrData[6:0] as the ROM bank. For addresses 4000-7FFF, romAddr then equals {bank, cpuAddr[13:0]}.
- R3: A stored ROM bank of 0 (including a write of 0x80) is presented as bank 1 in 4000-7FFF.
- R4: A write to 0000-1FFF enables the A000-BFFF window when cpuWrData[3:0] is 0xA and disables it otherwise. While the window is disabled, reads in A000-BFFF return 0xFF and ramCs and ramWe stay low. Reads at any address outside A000-BFFF return 0xFF.
- R5: A write to 4000-5FFF stores cpuWrData[3:0] as the select code. Codes 0-3, with the window enabled, assert ramCs for A000-BFFF accesses. In that case ramAddr is {code[1:0], cpuAddr[12:0]}, cpuRdData passes ramRdData through, and ramWe equals ramCs AND cpuWr.
- R6: With the window enabled, the following select codes read the latched clock:
  - 0x8: seconds {2'b0, sec}
  - 0x9: minutes {2'b0, min}
  - 0xA: hours {3'b0, hr}
  - 0xB: day[7:0]
  - 0xC: {carry, halt, 5'b0, day[8]}

  Codes 4-7 and 0xD-0xF read 0xFF and never assert ramCs.
- R7: Two consecutive writes to 6000-7FFF, of 0x00 and then 0x01, copy all running clock fields into the latched set at the clock edge of the 0x01 write. The latched set changes at no other time. Writes of 0x01 after 0x01, or of 0x01 after 0x02, do not latch.
- R8: On each cycle with secTick high, and with the clock neither halted nor being written, seconds advance. A field at or above its top value (59, 59, 23) wraps to 0 and carries into the next field. A day count of 511 wraps to 0 and sets carry. Carry stays set until it is written.
- R9: While halt is set, secTick leaves all running clock fields unchanged.
- R10: A write in A000-BFFF with the window enabled and select code 0x8-0xC loads the addressed running field: sec=d[5:0], min=d[5:0], hr=d[4:0], day[7:0]=d, or {carry,halt,day[8]}={d[7],d[6],d[0]}. No tick advance happens in that cycle.
- R11: After reset the stored ROM bank is 0 (seen as bank 1), the select code is 0, the window is disabled, and all running and latched clock fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse once per second |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe, one cycle per write |
| ramRdData | input | 8 | Data returned by the external RAM |
| romAddr | output | 21 | Physical ROM address {bank, offset} |
| ramAddr | output | 15 | Physical RAM address {bank, offset} |
| ramCs | output | 1 | External RAM select |
| ramWe | output | 1 | External RAM write enable |
| cpuRdData | output | 8 | Data for CPU reads of the A000-BFFF window |

## Verification
The ROM mapping is tried with banks 0, 5, 0x7F and 0x80 written at both ends of the bank register range. This separates a correct zero remap from a missing one, and shows whether bit 7 is truncated. The enable is tried with 0x0A, 0x1A and 0x0B, to tell nibble-only decode from whole-byte decode. All four RAM codes and several unmapped codes show that window routing follows the select. The clock is loaded to 23:59:58 on day 511 and ticked across the full rollover. It is then halted, written in the same cycle as a tick, and latched with correct and broken command pairs. This tells apart carry chaining, halt gating, write priority and the edge-only nature of the latch.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 9;

  localparam logic [3:0] SEL_SEC = 4'h8;
  localparam logic [3:0] SEL_MIN = 4'h9;
  localparam logic [3:0] SEL_HR  = 4'hA;
  localparam logic [3:0] SEL_DLO = 4'hB;
  localparam logic [3:0] SEL_DHI = 4'hC;

  typedef struct packed {
    logic enWr;
    logic bankWr;
    logic selWr;
    logic latch;
    logic rtcWr;
    logic winHit;
  } cbc_strobe_t;

endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  addrTop,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWr,
  output cbc_strobe_t strobe
);

  logic prevZero;
  logic latchRegWr;

  assign latchRegWr = cpuWr && (addrTop == 3'b011);

  always_comb begin
    strobe.enWr   = cpuWr && (addrTop == 3'b000);
    strobe.bankWr = cpuWr && (addrTop == 3'b001);
    strobe.selWr  = cpuWr && (addrTop == 3'b010);
    strobe.winHit = (addrTop == 3'b101);
    strobe.rtcWr  = cpuWr && strobe.winHit;
    strobe.latch  = latchRegWr && (cpuWrData == 8'h01) && prevZero;
  end

  // remembers whether the last latch-region write was 0x00
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevZero <= 1'b0;
    end else if (latchRegWr) begin
      prevZero <= (cpuWrData == 8'h00);
    end
  end

  AST_LATCH_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |-> (cpuWr && cpuWrData == 8'h01)); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enWr, strobe.bankWr, strobe.selWr, latchRegWr, strobe.rtcWr})); // R4

endmodule

// File: rtl/cbc_datapath.sv
module cbc_datapath
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANKS  = 4,
  localparam int RAM_SEL_W = $clog2(RAM_BANKS),
  localparam int ROM_ADDR_W = ROM_BANK_W + 14,
  localparam int RAM_ADDR_W = RAM_SEL_W + 13
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic [14:0]           cpuAddr,
  input  logic [7:0]            cpuWrData,
  input  logic                  cpuWr,
  input  logic [7:0]            ramRdData,
  input  cbc_strobe_t           strobe,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramCs,
  output logic                  ramWe,
  output logic [7:0]            cpuRdData
);

  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(23);
  localparam logic [DAY_W-1:0] DAY_TOP = {DAY_W{1'b1}};

  logic                  ramEn;
  logic [ROM_BANK_W-1:0] romBank;
  logic [ROM_BANK_W-1:0] bankEff;
  logic [3:0]            sel;

  logic [SEC_W-1:0] sec,    latSec;
  logic [MIN_W-1:0] minute, latMin;
  logic [HR_W-1:0]  hour,   latHr;
  logic [DAY_W-1:0] day,    latDay;
  logic             halt,   latHalt;
  logic             carry,  latCarry;

  logic rtcSelValid;
  logic ramSelValid;
  logic rtcWrEn;
  logic tickEn;

  // ---------------- ROM mapping ----------------
  assign bankEff = (romBank == '0) ? ROM_BANK_W'(1) : romBank;
  assign romAddr = {(cpuAddr[14] ? bankEff : {ROM_BANK_W{1'b0}}), cpuAddr[13:0]};

  AST_FIXED_BANK0: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAddr[14] |-> (romAddr[ROM_ADDR_W-1:14] == '0)); // R1

  AST_SWITCH_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cpuAddr[14] |-> (romAddr[ROM_ADDR_W-1:14] != '0)); // R3

  // ---------------- window routing ----------------
  assign rtcSelValid = (sel >= SEL_SEC) && (sel <= SEL_DHI);
  assign ramSelValid = (32'(sel) < RAM_BANKS);
  assign ramCs   = strobe.winHit && ramEn && ramSelValid;
  assign ramWe   = ramCs && cpuWr;
  assign ramAddr = {sel[RAM_SEL_W-1:0], cpuAddr[12:0]};

  always_comb begin
    cpuRdData = 8'hFF;
    if (strobe.winHit && ramEn) begin
      if (ramSelValid) begin
        cpuRdData = ramRdData;
      end else begin
        case (sel)
          SEL_SEC: cpuRdData = 8'(latSec);
          SEL_MIN: cpuRdData = 8'(latMin);
          SEL_HR:  cpuRdData = 8'(latHr);
          SEL_DLO: cpuRdData = latDay[7:0];
          SEL_DHI: cpuRdData = {latCarry, latHalt, 5'b0, latDay[8]};
          default: cpuRdData = 8'hFF;
        endcase
      end
    end
  end

  AST_WIN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.winHit && !ramEn) |-> (cpuRdData == 8'hFF && !ramCs && !ramWe)); // R4

  AST_RTC_NO_RAM: assert property (@(posedge clk) disable iff (!rstN)
    rtcSelValid |-> !ramCs); // R6

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramEn   <= 1'b0;
      romBank <= '0;
      sel     <= '0;
    end else begin
      if (strobe.enWr)   ramEn   <= (cpuWrData[3:0] == 4'hA);
      if (strobe.bankWr) romBank <= cpuWrData[ROM_BANK_W-1:0];
      if (strobe.selWr)  sel     <= cpuWrData[3:0];
    end
  end

  // ---------------- clock counters ----------------
  assign rtcWrEn = strobe.rtcWr && ramEn && rtcSelValid;
  assign tickEn  = secTick && !halt && !rtcWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec    <= '0;
      minute <= '0;
      hour   <= '0;
      day    <= '0;
      halt   <= 1'b0;
      carry  <= 1'b0;
    end else if (rtcWrEn) begin
      case (sel)
        SEL_SEC: sec    <= cpuWrData[SEC_W-1:0];
        SEL_MIN: minute <= cpuWrData[MIN_W-1:0];
        SEL_HR:  hour   <= cpuWrData[HR_W-1:0];
        SEL_DLO: day[7:0] <= cpuWrData;
        default: begin
          day[8] <= cpuWrData[0];
          halt   <= cpuWrData[6];
          carry  <= cpuWrData[7];
        end
      endcase
    end else if (tickEn) begin
      if (sec >= SEC_TOP) begin
        sec <= '0;
        if (minute >= MIN_TOP) begin
          minute <= '0;
          if (hour >= HR_TOP) begin
            hour <= '0;
            if (day == DAY_TOP) begin
              day   <= '0;
              carry <= 1'b1;
            end else begin
              day <= day + 1'b1;
            end
          end else begin
            hour <= hour + 1'b1;
          end
        end else begin
          minute <= minute + 1'b1;
        end
      end else begin
        sec <= sec + 1'b1;
      end
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && sec >= SEC_TOP) |=> (sec == '0)); // R8

  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && sec >= SEC_TOP && minute >= MIN_TOP && hour >= HR_TOP && day == DAY_TOP)
      |=> carry); // R8

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (halt && !rtcWrEn) |=> ($stable(sec) && $stable(minute) && $stable(hour) && $stable(day))); // R9

  // ---------------- latched copy ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latSec   <= '0;
      latMin   <= '0;
      latHr    <= '0;
      latDay   <= '0;
      latHalt  <= 1'b0;
      latCarry <= 1'b0;
    end else if (strobe.latch) begin
      latSec   <= sec;
      latMin   <= minute;
      latHr    <= hour;
      latDay   <= day;
      latHalt  <= halt;
      latCarry <= carry;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.latch) |-> ($stable(latSec) && $stable(latMin) && $stable(latHr)
                              && $stable(latDay) && $stable(latHalt) && $stable(latCarry))); // R7

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANKS  = 4,
  localparam int ROM_ADDR_W = ROM_BANK_W + 14,
  localparam int RAM_ADDR_W = $clog2(RAM_BANKS) + 13
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic [15:0]           cpuAddr,
  input  logic [7:0]            cpuWrData,
  input  logic                  cpuWr,
  input  logic [7:0]            ramRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramCs,
  output logic                  ramWe,
  output logic [7:0]            cpuRdData
);

  cbc_strobe_t strobe;

  cbc_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .addrTop   (cpuAddr[15:13]),
    .cpuWrData (cpuWrData),
    .cpuWr     (cpuWr),
    .strobe    (strobe)
  );

  cbc_datapath #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANKS  (RAM_BANKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .secTick   (secTick),
    .cpuAddr   (cpuAddr[14:0]),
    .cpuWrData (cpuWrData),
    .cpuWr     (cpuWr),
    .ramRdData (ramRdData),
    .strobe    (strobe),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramCs     (ramCs),
    .ramWe     (ramWe),
    .cpuRdData (cpuRdData)
  );

endmodule

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWr = 1'b0;
  logic [7:0]  ramRdData = '0;
  logic [20:0] romAddr;
  logic [14:0] ramAddr;
  logic        ramCs;
  logic        ramWe;
  logic [7:0]  cpuRdData;

  always #4 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuWr(cpuWr), .ramRdData(ramRdData),
    .romAddr(romAddr), .ramAddr(ramAddr), .ramCs(ramCs), .ramWe(ramWe),
    .cpuRdData(cpuRdData)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string phaseTag = "";

  // behavioural reference state
  int mEn = 0, mBank = 0, mSel = 0, mPz = 0;
  int mSec = 0, mMin = 0, mHr = 0, mDay = 0, mHalt = 0, mCarry = 0;
  int lSec = 0, lMin = 0, lHr = 0, lDay = 0, lHalt = 0, lCarry = 0;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int expRd(input int a, input int rd);
    if (a < 'hA000 || a > 'hBFFF) return 'hFF;
    if (mEn == 0) return 'hFF;
    if (mSel < 4) return rd;
    case (mSel)
      8:  return lSec;
      9:  return lMin;
      10: return lHr;
      11: return lDay & 255;
      12: return (lCarry << 7) | (lHalt << 6) | (lDay >> 8);
      default: return 'hFF;
    endcase
  endfunction

  task automatic modelStep(input int a, input int d, input bit wr, input bit tk);
    bit rtcW = 0;
    bit lat = 0;
    bool_dummy: begin end
    if (wr) begin
      if (a < 'h2000) mEn = ((d & 15) == 10);
      else if (a < 'h4000) mBank = d & 127;
      else if (a < 'h6000) mSel = d & 15;
      else if (a < 'h8000) begin
        if (d == 1 && mPz == 1) lat = 1;
        mPz = (d == 0);
      end else if (a >= 'hA000 && a <= 'hBFFF && mEn == 1 && mSel >= 8 && mSel <= 12)
        rtcW = 1;
    end
    if (lat) begin
      lSec = mSec; lMin = mMin; lHr = mHr; lDay = mDay; lHalt = mHalt; lCarry = mCarry;
    end
    if (rtcW) begin
      case (mSel)
        8:  mSec = d & 63;
        9:  mMin = d & 63;
        10: mHr = d & 31;
        11: mDay = (mDay & 256) | d;
        default: begin
          mDay = (mDay & 255) | ((d & 1) << 8);
          mHalt = (d >> 6) & 1;
          mCarry = (d >> 7) & 1;
        end
      endcase
    end else if (tk && mHalt == 0) begin
      if (mSec >= 59) begin
        mSec = 0;
        if (mMin >= 59) begin
          mMin = 0;
          if (mHr >= 23) begin
            mHr = 0;
            if (mDay == 511) begin mDay = 0; mCarry = 1; end
            else mDay = mDay + 1;
          end else mHr = mHr + 1;
        end else mMin = mMin + 1;
      end else mSec = mSec + 1;
    end
  endtask

  // one bus cycle: drive at negedge, compare, then advance model at posedge
  task automatic cyc(input int a, input int d, input bit wr, input bit tk);
    int rd;
    int eBank;
    int eRom;
    bit eCs;
    string tRom, tRd, tCs;
    cpuAddr = 16'(a);
    cpuWrData = 8'(d);
    cpuWr = wr;
    secTick = tk;
    rd = (a & 255) ^ 'h5A;
    ramRdData = 8'(rd);
    #1;
    eBank = (mBank == 0) ? 1 : mBank;
    eRom = ((((a >> 14) & 1) == 1) ? (eBank << 14) : 0) | (a & 16383);
    eCs = (a >= 'hA000 && a <= 'hBFFF && mEn == 1 && mSel < 4);
    tRom = (a < 'h4000) ? "R1" : ((mBank == 0) ? "R3" : "R2");
    tCs = (mEn == 0) ? "R4" : "R5";
    if (a < 'hA000 || a > 'hBFFF || mEn == 0) tRd = "R4";
    else if (mSel < 4) tRd = "R5";
    else tRd = "R6";
    if (phaseTag != "") begin tRom = phaseTag; tRd = phaseTag; tCs = phaseTag; end
    if (a < 'h8000) chk(tRom, int'(romAddr), eRom, "romAddr");
    chk(tRd, int'(cpuRdData), expRd(a, rd), "cpuRdData");
    chk(tCs, int'(ramCs), int'(eCs), "ramCs");
    chk(tCs, int'(ramWe), int'(eCs && wr), "ramWe");
    if (eCs) chk(tCs, int'(ramAddr), ((mSel & 3) << 13) | (a & 8191), "ramAddr");
    @(posedge clk);
    if (rstN) modelStep(a, d, wr, tk);
    @(negedge clk);
    cpuWr = 1'b0;
    secTick = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    cyc(a, d, 1'b1, 1'b0);
  endtask

  task automatic rd(input int a);
    cyc(a, 0, 1'b0, 1'b0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc('hA000, 0, 1'b0, 1'b1);
  endtask

  task automatic latchNow();
    wr('h6000, 0);
    wr('h7FFF, 1);
  endtask

  task automatic readClock(input string tag);
    for (int s = 8; s <= 12; s++) begin
      wr('h4000, s);
      phaseTag = tag;
      rd('hA000 + s);
      phaseTag = "";
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: reset state, observed both during and after reset
    phaseTag = "R11";
    cyc('h4000, 0, 1'b0, 1'b1);
    cyc('hA000, 0, 1'b0, 1'b0);
    rstN = 1'b1;
    rd('h4123);
    rd('hA000);
    phaseTag = "";
    wr('h0000, 'h0A);
    readClock("R11");
    wr('h0000, 'h00);

    // R1 / R2: fixed and switched ROM banks
    wr('h2000, 5);
    rd('h0123);
    rd('h3FFF);
    rd('h4ABC);
    rd('h7FFF);
    wr('h3FFF, 'h7F);
    rd('h4000);
    rd('h3000);
    wr('h2100, 'h85);
    rd('h6001);

    // R3: bank zero remap, including bit-7 truncation
    wr('h2000, 0);
    rd('h4000);
    rd('h7FFF);
    wr('h3000, 'h80);
    rd('h5555);
    wr('h2000, 2);
    rd('h4000);

    // R4: enable decode
    rd('hA000);
    wr('hA010, 'h33);
    wr('h0000, 'h0A);
    rd('hA001);
    wr('h1FFF, 'h1A);
    rd('hB002);
    wr('h0100, 'h0B);
    rd('hA003);
    wr('hA004, 'h44);
    rd('h8000);
    wr('h0000, 'hFA);

    // R5: four RAM banks
    for (int b = 0; b < 4; b++) begin
      wr('h4000 + b, b);
      rd('hA000 + b * 'h111);
      wr('hBFFF - b, 'h20 + b);
    end
    wr('h5FFF, 'h14);
    rd('hA100);

    // R10 / R6: load running clock to 23:59:58 day 511, latch, read back
    phaseTag = "R10";
    wr('h4000, 8);   wr('hA000, 58);
    wr('h4000, 9);   wr('hA000, 59);
    wr('h4000, 10);  wr('hA000, 23);
    wr('h4000, 11);  wr('hA000, 'hFF);
    wr('h4000, 12);  wr('hA000, 'h01);
    phaseTag = "";
    latchNow();
    readClock("R6");
    wr('h4000, 5);
    rd('hA000);
    wr('h4000, 'hD);
    rd('hA000);
    wr('h4000, 'hF);
    rd('hBFFF);

    // R8: full rollover sets carry
    tick(2);
    latchNow();
    readClock("R8");
    tick(61);
    latchNow();
    readClock("R8");
    wr('h4000, 12);
    wr('hA000, 'h00);
    latchNow();
    readClock("R8");

    // R9: halted clock ignores ticks
    wr('h4000, 12);
    wr('hA000, 'h40);
    tick(5);
    latchNow();
    readClock("R9");
    wr('h4000, 12);
    wr('hA000, 'h00);
    tick(3);
    latchNow();
    readClock("R9");

    // R10: write in the same cycle as a tick wins
    wr('h4000, 8);
    cyc('hA000, 10, 1'b1, 1'b1);
    latchNow();
    readClock("R10");

    // R7: broken command pairs do not latch
    tick(4);
    wr('h6000, 1);
    wr('h6000, 1);
    readClock("R7");
    wr('h6000, 0);
    wr('h6000, 2);
    wr('h6000, 1);
    readClock("R7");
    wr('h6000, 0);
    wr('h2000, 3);
    wr('h6000, 1);
    readClock("R7");
    tick(2);
    readClock("R7");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule